// File: doc/BRIEF.md
# Debug Exception Controller

This block sits next to an in-order instruction sequencer and decides, at each instruction boundary, whether a debug exception must be raised. It works in one of two ways. A fault is raised before the instruction runs; the causes are an instruction-address match or a debug-register access that an external emulator currently owns. A trap is raised after the instruction completes; the causes are a single-step, a data-address match, a task switch into a task with its trap bit set, or a one-byte breakpoint instruction. Address comparison and the stack push happen elsewhere, so matches arrive at the block as per-boundary flags.

The sequencer presents one boundary per `bnd_valid` cycle. The block keeps two flags:
- The restart flag, which masks instruction-address faults while a faulting instruction is retried.
- The step flag, which arms single-step for the following instruction.

When an exception is due, the block loads a cause register and issues a one-cycle request carrying the vector and a fault/trap indication. It then waits for `hnd_ack`. The acknowledge cycle is also where a pending external interrupt is sampled, so that the interrupt can be serviced before the first handler instruction.

Top module: `dbgx_ctrl`

## Requirements
- R1: After reset, `exc_req`, `irq_take`, `busy`, `restart_flag`, `step_flag` and `dbg_status` are all 0.
- R2: Debug fault from an instruction-address match.
  - When `iab_hit` is nonzero and the restart flag is 0, the cycle after the boundary carries `exc_req`=1, `exc_fault`=1 and `exc_vec`=1.
  - The matching hit bits are set in the status.
  - The instruction counts as not executed.
- R3: While the restart flag is 1, `iab_hit` raises no fault at that boundary. Traps of that instruction are still reported.
- R4: Restart flag behaviour.
  - It becomes 1 at any faulting boundary: a debug fault, or `oth_fault` without a debug fault.
  - It becomes `ld_rf` when a completing instruction has `flags_ld`=1.
  - It becomes 0 on any other completion.
  - It therefore stays 1 across repeated faults.
- R5: A single-step trap (vector 1, `exc_fault`=0, step status bit set) occurs at a completing boundary only if the step flag was 1 before that boundary. An instruction that loads the step flag with 1 does not trap itself.
- R6: Step flag updates.
  - It becomes 0 whenever a request is issued.
  - It becomes 0 on completion of `swint` or `brk_insn`.
  - It becomes `ld_tf` on completion with `flags_ld`=1.
  - A non-debug fault leaves it unchanged.
- R7: Data-address matches.
  - With `exact_en`=1, `dab_hit` is reported as a trap at the same boundary.
  - With `exact_en`=0, it is reported at the next accepted boundary that is not an `oth_fault`. There it is merged into whatever vector-1 request that boundary makes, including a fault.
- R8: `gd_hit` raises a vector-1 fault with status bit NBP set.
- R9: `tsw_trap` on a completing boundary raises a vector-1 trap with status bit NBP+2 set.
- R10: Status register.
  - Layout: bits NBP-1..0 are the address hits, bit NBP is general detect, bit NBP+1 is single-step, bit NBP+2 is task switch.
  - A vector-1 request loads it with all causes of that report at once.
  - It keeps its value in every cycle without a request.
- R11: `brk_insn` on a completing boundary raises a vector-3 trap and leaves the status unchanged.
  - If vector-1 conditions are also present, the vector-1 trap is issued first.
  - The vector-3 trap then follows in the cycle after that request is acknowledged.
- R12: External interrupt.
  - If an accepted boundary issues no request, `irq_take` equals `ext_irq` one cycle later.
  - If it does issue a request, `ext_irq` is sampled in the final acknowledge cycle and `irq_take` follows one cycle after.
  - A request and `irq_take` never coincide.
- R13: From the request until the acknowledge, `busy` is 1, and `bnd_valid` together with its event inputs is ignored.
- R14: A debug fault overrides everything else on that boundary: `dab_hit`, `tsw_trap`, `brk_insn`, the flag loads and `oth_fault`. An `oth_fault` with no debug fault issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_valid | input | 1 | Instruction boundary presented this cycle |
| iab_hit | input | NBP | Instruction-address matches for the instruction about to run |
| dab_hit | input | NBP | Data-address matches of the instruction |
| exact_en | input | 1 | Report data matches at this boundary |
| gd_hit | input | 1 | Debug-register access while the emulator owns them |
| oth_fault | input | 1 | Instruction raised a non-debug fault |
| tsw_trap | input | 1 | Task switch into a task whose trap bit is set |
| brk_insn | input | 1 | Instruction is the one-byte breakpoint |
| swint | input | 1 | Instruction is a software interrupt |
| flags_ld | input | 1 | Instruction loads the flags from a memory image |
| ld_rf | input | 1 | Restart flag value in that image |
| ld_tf | input | 1 | Step flag value in that image |
| ext_irq | input | 1 | External interrupt pending |
| hnd_ack | input | 1 | Handler entry acknowledged |
| exc_req | output | 1 | One-cycle exception request |
| exc_fault | output | 1 | Request is a fault (1) or a trap (0) |
| exc_vec | output | VW | Vector number of the request |
| dbg_status | output | NBP+3 | Cause bits of the last vector-1 report |
| irq_take | output | 1 | One-cycle grant to service the external interrupt |
| busy | output | 1 | Waiting for handler acknowledge |
| restart_flag | output | 1 | Current restart flag |
| step_flag | output | 1 | Current single-step flag |

## Verification
The bench builds the block with NBP=2, so both address-hit bits and every cause bit fit in a 14-bit stimulus word. It walks all 16384 values of that word in sequence. Because the restart flag, the step flag and the deferred data hits carry over from step to step, these combinations arrive with varied prior flag states. Expected requests, vectors, status values and flag values come from a bench model of the requirements. Directed sequences cover the cases the sweep cannot order on purpose: a nested fault under the restart flag, the vector-1 then vector-3 chain, the interrupt sampled at acknowledge, and a boundary offered while busy.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } dbgx_state_e;

  // cause register field positions, relative to the number of address comparators
  function automatic int unsigned gdet_pos(input int unsigned nbp);
    return nbp;
  endfunction

  function automatic int unsigned sstep_pos(input int unsigned nbp);
    return nbp + 1;
  endfunction

  function automatic int unsigned tswitch_pos(input int unsigned nbp);
    return nbp + 2;
  endfunction

endpackage

// File: rtl/dbgx_cause.sv
module dbgx_cause #(
  parameter int unsigned NBP = 4,
  localparam int unsigned SW = NBP + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_en,
  input  logic           restart_q,
  input  logic           step_q,
  input  logic [NBP-1:0] iab_hit,
  input  logic [NBP-1:0] dab_hit,
  input  logic           exact_en,
  input  logic           gd_hit,
  input  logic           oth_fault,
  input  logic           tsw_trap,
  input  logic           brk_insn,
  output logic           dbg_fault,
  output logic           take_v1,
  output logic           take_v3,
  output logic [SW-1:0]  cause_bits
);
  import dbgx_pkg::*;

  logic [NBP-1:0] dly_q;
  logic [NBP-1:0] dly_d;
  logic [NBP-1:0] iab_live;
  logic [NBP-1:0] trap_hits;
  logic           insn_done;
  logic           trap_any;

  // instruction-address matches masked by the restart flag
  assign iab_live  = iab_hit & {NBP{~restart_q}};
  assign dbg_fault = (|iab_live) | gd_hit;
  assign insn_done = ~dbg_fault & ~oth_fault;

  // data hits of this instruction (exact) merged with the ones deferred from the last one
  assign trap_hits = (exact_en ? dab_hit : {NBP{1'b0}}) | dly_q;
  assign trap_any  = insn_done & ((|trap_hits) | step_q | tsw_trap);

  assign take_v1 = dbg_fault | trap_any;
  assign take_v3 = insn_done & brk_insn;

  always_comb begin
    cause_bits = '0;
    if (dbg_fault) begin
      cause_bits[NBP-1:0]        = iab_live | dly_q;
      cause_bits[gdet_pos(NBP)]  = gd_hit;
    end else begin
      cause_bits[NBP-1:0]          = trap_hits;
      cause_bits[sstep_pos(NBP)]   = step_q;
      cause_bits[tswitch_pos(NBP)] = tsw_trap;
    end
  end

  always_comb begin
    dly_d = dly_q;
    if (dbg_fault) begin
      dly_d = '0;
    end else if (oth_fault) begin
      dly_d = dly_q;
    end else if (exact_en) begin
      dly_d = '0;
    end else begin
      dly_d = dab_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (step_en) begin
      dly_q <= dly_d;
    end
  end

  // a suppressed address match alone never produces a fault
  AST_RESTART_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_q && !gd_hit) |-> !dbg_fault); // R3

endmodule

// File: rtl/dbgx_flags.sv
module dbgx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic dbg_fault,
  input  logic oth_fault,
  input  logic entry,
  input  logic flags_ld,
  input  logic ld_restart,
  input  logic ld_step,
  input  logic sw_int,
  output logic restart_q,
  output logic step_q
);

  logic restart_d;
  logic step_d;

  always_comb begin
    restart_d = restart_q;
    if (dbg_fault || oth_fault) begin
      restart_d = 1'b1;
    end else if (flags_ld) begin
      restart_d = ld_restart;
    end else begin
      restart_d = 1'b0;
    end
  end

  always_comb begin
    step_d = step_q;
    if (entry) begin
      step_d = 1'b0;
    end else if (oth_fault) begin
      step_d = step_q;
    end else if (flags_ld) begin
      step_d = ld_step;
    end else if (sw_int) begin
      step_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      step_q    <= 1'b0;
    end else if (step_en) begin
      restart_q <= restart_d;
      step_q    <= step_d;
    end
  end

  // a non-debug fault never disturbs the step flag
  AST_OTHER_FAULT_KEEPS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && oth_fault && !dbg_fault) |=> (step_q == $past(step_q))); // R6

endmodule

// File: rtl/dbgx_seq.sv
module dbgx_seq #(
  parameter int unsigned NBP = 4,
  parameter int unsigned VW = 8,
  parameter logic [VW-1:0] VEC_DBG = 1,
  parameter logic [VW-1:0] VEC_BRK = 3,
  localparam int unsigned SW = NBP + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_valid,
  input  logic          hnd_ack,
  input  logic          ext_irq,
  input  logic          dbg_fault,
  input  logic          take_v1,
  input  logic          take_v3,
  input  logic [SW-1:0] cause_bits,
  output logic          step_en,
  output logic          exc_req,
  output logic          exc_fault,
  output logic [VW-1:0] exc_vec,
  output logic [SW-1:0] dbg_status,
  output logic          irq_take,
  output logic          busy
);
  import dbgx_pkg::*;

  dbgx_state_e   state_q, state_d;
  logic          req_q, req_d;
  logic          flt_q, flt_d;
  logic [VW-1:0] vec_q, vec_d;
  logic [SW-1:0] stat_q, stat_d;
  logic          stat_en;
  logic          irq_q, irq_d;
  logic          p3_q, p3_d;

  assign step_en = bnd_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    flt_d   = flt_q;
    vec_d   = vec_q;
    stat_d  = stat_q;
    stat_en = 1'b0;
    irq_d   = 1'b0;
    p3_d    = p3_q;
    case (state_q)
      ST_IDLE: begin
        if (step_en) begin
          if (take_v1) begin
            req_d   = 1'b1;
            flt_d   = dbg_fault;
            vec_d   = VEC_DBG;
            stat_d  = cause_bits;
            stat_en = 1'b1;
            p3_d    = take_v3;
            state_d = ST_WAIT;
          end else if (take_v3) begin
            req_d   = 1'b1;
            flt_d   = 1'b0;
            vec_d   = VEC_BRK;
            state_d = ST_WAIT;
          end else begin
            irq_d = ext_irq;
          end
        end
      end
      ST_WAIT: begin
        if (hnd_ack) begin
          if (p3_q) begin
            req_d = 1'b1;
            flt_d = 1'b0;
            vec_d = VEC_BRK;
            p3_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
            irq_d   = ext_irq;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      flt_q   <= 1'b0;
      vec_q   <= '0;
      irq_q   <= 1'b0;
      p3_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      flt_q   <= flt_d;
      vec_q   <= vec_d;
      irq_q   <= irq_d;
      p3_q    <= p3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign exc_req    = req_q;
  assign exc_fault  = flt_q;
  assign exc_vec    = vec_q;
  assign dbg_status = stat_q;
  assign irq_take   = irq_q;
  assign busy       = (state_q == ST_WAIT);

  // a queued breakpoint request follows only an acknowledged debug trap
  AST_BRK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hnd_ack && p3_q) |=> (exc_req && !exc_fault)); // R11

endmodule

// File: rtl/dbgx_ctrl.sv
module dbgx_ctrl #(
  parameter int unsigned NBP = 4,
  parameter int unsigned VW = 8,
  parameter logic [VW-1:0] VEC_DBG = 1,
  parameter logic [VW-1:0] VEC_BRK = 3,
  localparam int unsigned SW = NBP + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bnd_valid,
  input  logic [NBP-1:0] iab_hit,
  input  logic [NBP-1:0] dab_hit,
  input  logic           exact_en,
  input  logic           gd_hit,
  input  logic           oth_fault,
  input  logic           tsw_trap,
  input  logic           brk_insn,
  input  logic           swint,
  input  logic           flags_ld,
  input  logic           ld_rf,
  input  logic           ld_tf,
  input  logic           ext_irq,
  input  logic           hnd_ack,
  output logic           exc_req,
  output logic           exc_fault,
  output logic [VW-1:0]  exc_vec,
  output logic [SW-1:0]  dbg_status,
  output logic           irq_take,
  output logic           busy,
  output logic           restart_flag,
  output logic           step_flag
);

  logic          step_en;
  logic          dbg_fault;
  logic          take_v1;
  logic          take_v3;
  logic [SW-1:0] cause_bits;

  dbgx_cause #(.NBP(NBP)) u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .restart_q  (restart_flag),
    .step_q     (step_flag),
    .iab_hit    (iab_hit),
    .dab_hit    (dab_hit),
    .exact_en   (exact_en),
    .gd_hit     (gd_hit),
    .oth_fault  (oth_fault),
    .tsw_trap   (tsw_trap),
    .brk_insn   (brk_insn),
    .dbg_fault  (dbg_fault),
    .take_v1    (take_v1),
    .take_v3    (take_v3),
    .cause_bits (cause_bits)
  );

  dbgx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .dbg_fault  (dbg_fault),
    .oth_fault  (oth_fault),
    .entry      (take_v1 | take_v3),
    .flags_ld   (flags_ld),
    .ld_restart (ld_rf),
    .ld_step    (ld_tf),
    .sw_int     (swint | brk_insn),
    .restart_q  (restart_flag),
    .step_q     (step_flag)
  );

  dbgx_seq #(
    .NBP     (NBP),
    .VW      (VW),
    .VEC_DBG (VEC_DBG),
    .VEC_BRK (VEC_BRK)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bnd_valid  (bnd_valid),
    .hnd_ack    (hnd_ack),
    .ext_irq    (ext_irq),
    .dbg_fault  (dbg_fault),
    .take_v1    (take_v1),
    .take_v3    (take_v3),
    .cause_bits (cause_bits),
    .step_en    (step_en),
    .exc_req    (exc_req),
    .exc_fault  (exc_fault),
    .exc_vec    (exc_vec),
    .dbg_status (dbg_status),
    .irq_take   (irq_take),
    .busy       (busy)
  );

  AST_FAULT_ARMS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_fault) |-> restart_flag); // R4

  AST_ENTRY_DROPS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !step_flag); // R6

  AST_BRK_IS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_vec == VEC_BRK) |-> !exc_fault); // R11

  AST_REQ_IRQ_APART: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !irq_take); // R12

  AST_BUSY_FREEZES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(restart_flag) && $stable(step_flag))); // R13

  AST_REQ_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> busy); // R13

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> $stable(dbg_status)); // R10

endmodule

// File: tb/sim_dbgx_ctrl.sv
`timescale 1ns/1ps
module sim_dbgx_ctrl;

  localparam int unsigned NBP = 2;
  localparam int unsigned VW  = 8;
  localparam int unsigned SW  = NBP + 3;

  localparam logic [13:0] S_IAB0 = 14'h0001;
  localparam logic [13:0] S_IAB1 = 14'h0002;
  localparam logic [13:0] S_DAB0 = 14'h0004;
  localparam logic [13:0] S_DAB1 = 14'h0008;
  localparam logic [13:0] S_EX   = 14'h0010;
  localparam logic [13:0] S_GD   = 14'h0020;
  localparam logic [13:0] S_OTH  = 14'h0040;
  localparam logic [13:0] S_TSW  = 14'h0080;
  localparam logic [13:0] S_BRK  = 14'h0100;
  localparam logic [13:0] S_SWI  = 14'h0200;
  localparam logic [13:0] S_FLD  = 14'h0400;
  localparam logic [13:0] S_LRF  = 14'h0800;
  localparam logic [13:0] S_LTF  = 14'h1000;
  localparam logic [13:0] S_IRQ  = 14'h2000;

  logic clk = 1'b0;
  logic rst_n;
  logic bnd_valid, exact_en, gd_hit, oth_fault, tsw_trap, brk_insn, swint;
  logic flags_ld, ld_rf, ld_tf, ext_irq, hnd_ack;
  logic [NBP-1:0] iab_hit, dab_hit;
  logic exc_req, exc_fault, irq_take, busy, restart_flag, step_flag;
  logic [VW-1:0] exc_vec;
  logic [SW-1:0] dbg_status;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic m_rf, m_tf;
  logic [NBP-1:0] m_dly;
  logic [SW-1:0] m_stat;
  logic e_req, e_flt, e_p3, e_irq;
  logic [VW-1:0] e_vec;

  always #2 clk = ~clk;

  dbgx_ctrl #(.NBP(NBP), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .iab_hit(iab_hit),
    .dab_hit(dab_hit), .exact_en(exact_en), .gd_hit(gd_hit),
    .oth_fault(oth_fault), .tsw_trap(tsw_trap), .brk_insn(brk_insn),
    .swint(swint), .flags_ld(flags_ld), .ld_rf(ld_rf), .ld_tf(ld_tf),
    .ext_irq(ext_irq), .hnd_ack(hnd_ack), .exc_req(exc_req),
    .exc_fault(exc_fault), .exc_vec(exc_vec), .dbg_status(dbg_status),
    .irq_take(irq_take), .busy(busy), .restart_flag(restart_flag),
    .step_flag(step_flag)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [13:0] s);
    iab_hit   = s[1:0];
    dab_hit   = s[3:2];
    exact_en  = s[4];
    gd_hit    = s[5];
    oth_fault = s[6];
    tsw_trap  = s[7];
    brk_insn  = s[8];
    swint     = s[9];
    flags_ld  = s[10];
    ld_rf     = s[11];
    ld_tf     = s[12];
    ext_irq   = s[13];
    bnd_valid = 1'b1;
  endtask

  // expected outcome of one accepted boundary, from the requirements
  task automatic predict(input logic [13:0] s);
    logic [NBP-1:0] dfb, tb;
    e_req = 0; e_flt = 0; e_vec = '0; e_p3 = 0; e_irq = 0;
    dfb = s[1:0] & {NBP{~m_rf}};
    if ((|dfb) || s[5]) begin
      e_req = 1; e_flt = 1; e_vec = 8'd1;
      m_stat = {1'b0, 1'b0, s[5], dfb | m_dly};
      m_dly = '0; m_rf = 1'b1; m_tf = 1'b0;
    end else if (s[6]) begin
      m_rf = 1'b1; e_irq = s[13];
    end else begin
      logic bs;
      tb = (s[4] ? s[3:2] : {NBP{1'b0}}) | m_dly;
      bs = m_tf;
      m_dly = s[4] ? {NBP{1'b0}} : s[3:2];
      m_rf = s[10] ? s[11] : 1'b0;
      m_tf = s[10] ? s[12] : ((s[8] | s[9]) ? 1'b0 : m_tf);
      if ((|tb) || bs || s[7]) begin
        e_req = 1; e_vec = 8'd1; e_p3 = s[8];
        m_stat = {s[7], bs, 1'b0, tb};
        m_tf = 1'b0;
      end else if (s[8]) begin
        e_req = 1; e_vec = 8'd3; m_tf = 1'b0;
      end else begin
        e_irq = s[13];
      end
    end
  endtask

  task automatic check_bnd(input string tag);
    chk(tag, "exc_req", {31'd0, exc_req}, {31'd0, e_req});
    if (e_req) begin
      chk(tag, "exc_fault", {31'd0, exc_fault}, {31'd0, e_flt});
      chk(tag, "exc_vec", {24'd0, exc_vec}, {24'd0, e_vec});
    end
    chk(tag, "dbg_status", {27'd0, dbg_status}, {27'd0, m_stat});
    chk(tag, "irq_take", {31'd0, irq_take}, {31'd0, e_irq});
    chk(tag, "restart_flag", {31'd0, restart_flag}, {31'd0, m_rf});
    chk(tag, "step_flag", {31'd0, step_flag}, {31'd0, m_tf});
    chk(tag, "busy", {31'd0, busy}, {31'd0, e_req});
  endtask

  task automatic finish_ack(input string tag, input logic irq);
    if (e_req) begin
      hnd_ack = 1'b1;
      @(negedge clk);
      hnd_ack = 1'b0;
      if (e_p3) begin
        chk(tag, "queued brk req", {31'd0, exc_req}, 32'd1);
        chk(tag, "queued brk vec", {24'd0, exc_vec}, 32'd3);
        chk(tag, "queued brk fault", {31'd0, exc_fault}, 32'd0);
        chk(tag, "queued brk status", {27'd0, dbg_status}, {27'd0, m_stat});
        chk(tag, "queued brk irq", {31'd0, irq_take}, 32'd0);
        hnd_ack = 1'b1;
        @(negedge clk);
        hnd_ack = 1'b0;
      end
      chk(tag, "irq at ack", {31'd0, irq_take}, {31'd0, irq});
      chk(tag, "busy after ack", {31'd0, busy}, 32'd0);
      chk(tag, "req after ack", {31'd0, exc_req}, 32'd0);
    end
  endtask

  task automatic step(input logic [13:0] s, input string tag);
    apply(s);
    @(negedge clk);
    bnd_valid = 1'b0;
    predict(s);
    check_bnd(tag);
    finish_ack(tag, s[13]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hnd_ack = 1'b0;
    apply(14'h0);
    bnd_valid = 1'b0;
    m_rf = 0; m_tf = 0; m_dly = '0; m_stat = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "exc_req", {31'd0, exc_req}, 32'd0);
    chk("R1", "irq_take", {31'd0, irq_take}, 32'd0);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "restart_flag", {31'd0, restart_flag}, 32'd0);
    chk("R1", "step_flag", {31'd0, step_flag}, 32'd0);
    chk("R1", "dbg_status", {27'd0, dbg_status}, 32'd0);

    // single-step armed by a flag load, trap on the following instruction
    step(S_FLD | S_LTF, "R5");
    step(14'h0, "R5");
    step(S_FLD | S_LTF, "R6");
    step(S_SWI, "R6");
    step(S_SWI, "R6");
    // address fault, then retry under the restart flag
    step(S_IAB0, "R2");
    step(S_IAB0 | S_TSW, "R3");
    step(S_IAB1, "R2");
    step(S_OTH, "R4");
    step(S_IAB1, "R4");
    step(S_FLD | S_LRF, "R4");
    step(S_IAB0 | S_IAB1, "R4");
    // data matches, exact and deferred
    step(S_DAB0 | S_EX, "R7");
    step(S_DAB1, "R7");
    step(14'h0, "R7");
    step(S_DAB0, "R7");
    step(S_GD, "R7");
    step(S_GD, "R8");
    step(S_FLD, "R4");
    step(S_TSW, "R9");
    step(S_FLD | S_LTF, "R10");
    step(S_TSW | S_DAB1 | S_DAB0 | S_EX, "R10");
    step(S_BRK, "R11");
    step(S_BRK | S_TSW | S_IRQ, "R11");
    step(S_IRQ, "R12");
    step(S_TSW | S_IRQ, "R12");
    step(S_IAB0 | S_TSW | S_DAB0 | S_EX | S_BRK | S_OTH | S_FLD | S_LTF, "R14");
    step(S_OTH | S_TSW | S_BRK, "R14");

    // boundaries offered while waiting for acknowledge are ignored
    apply(S_TSW);
    @(negedge clk);
    predict(S_TSW);
    check_bnd("R13");
    apply(S_GD | S_FLD | S_LTF | S_LRF | S_IAB0);
    repeat (2) @(negedge clk);
    bnd_valid = 1'b0;
    chk("R13", "no new req", {31'd0, exc_req}, 32'd0);
    chk("R13", "restart_flag", {31'd0, restart_flag}, {31'd0, m_rf});
    chk("R13", "step_flag", {31'd0, step_flag}, {31'd0, m_tf});
    chk("R13", "busy", {31'd0, busy}, 32'd1);
    ext_irq = 1'b0;
    finish_ack("R13", 1'b0);
    chk("R13", "status kept", {27'd0, dbg_status}, {27'd0, m_stat});

    // sweep of every stimulus word with carried-over flag state
    for (int i = 0; i < 16384; i++) begin
      step(i[13:0] ^ {i[6:0], 7'd0}, "R10 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule